// File: doc/BRIEF.md
# Unsolicited Response Injector

This block sits on the return path of a memory responder. It forwards the responder's normal response beats, and, when enabled, it also inserts stray beats that answer no request. Each stray beat is marked by a tag output so that downstream observers can discard it. These beats are used to test how a requester copes with responses it never asked for.

Injection is paced by a down-counter. Each reload takes a value in a configured range [min, max], drawn from an internal linear-feedback shift register. Injection only happens while no accesses are outstanding. A new request arriving in the same tick always wins over injection. The injected payload is a 39-bit codeword supplied from outside: 32 data bits plus 7 integrity bits. The block does not compute integrity. All outputs are registered, so every result appears one clock after the tick that decides it. The reset is synchronous and active high.

Top module: `unsol_inject`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are driven low after that edge. The LFSR is set to the seed (default 16'hACE1). The counter is loaded with `min + (seed mod span)`, where span = max − min + 1, or span = 1 when max < min.
- R2: No injected beat is produced after any tick in which `outstanding_i` is nonzero.
- R3: A tick with `req_new_i` high produces no injected beat and leaves the counter unchanged.
- R4: A tick injects when all of the following hold: enabled, counter zero, `outstanding_i` zero, `req_new_i` low, `rsp_valid_i` low, and the previous tick did not inject. On injection, the LFSR steps once and the counter reloads with `min + (new LFSR mod span)`. The LFSR is 16-bit and shifts left, with feedback bit 0 = XOR of bits 15, 13, 12 and 10.
- R5: On an enabled tick without a request and without injection, a nonzero counter decrements by one. A zero counter stays at zero until it can inject.
- R6: An injecting tick yields, one clock later, `rsp_valid_o`=1, `rsp_unsol_o`=1, `rsp_word_o`=`inj_word_i` (39 bits) and `rsp_err_o`=`inj_err_i`, all sampled at that tick.
- R7: `rsp_valid_o` and `rsp_unsol_o` are low in the cycle after an injected beat. Two injected beats are never adjacent, even with min = max = 0.
- R8: A normal beat (`rsp_valid_i`=1) appears one clock later with its word and error bit unchanged and with `rsp_unsol_o`=0. It takes precedence over injection in the same tick. With no beat, `rsp_word_o` and `rsp_err_o` are zero.
- R9: With `en_i` low, `rsp_unsol_o` never rises, the counter holds, and normal beats pass as in R8.
- R10: The default range 0..100 fits the counter width. A reversed range (max < min) reloads exactly min every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enables injection |
| outstanding_i | input | OUT_W (4) | Number of accesses awaiting a response |
| req_new_i | input | 1 | A new request is being accepted this tick |
| dly_min_i | input | CNT_W (8) | Lower bound of the reload delay |
| dly_max_i | input | CNT_W (8) | Upper bound of the reload delay |
| inj_word_i | input | 39 | Precomputed codeword for injected beats |
| inj_err_i | input | 1 | Error bit for injected beats |
| rsp_valid_i | input | 1 | Normal response beat valid |
| rsp_word_i | input | 39 | Normal response codeword |
| rsp_err_i | input | 1 | Normal response error bit |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_word_o | output | 39 | Response codeword |
| rsp_err_o | output | 1 | Response error bit |
| rsp_unsol_o | output | 1 | Beat belongs to no request |

## Verification
Every output is due exactly one clock after the tick whose inputs decide it. This holds for forwarded beats, injected beats and the reset values. The counter effects show up later, as the spacing between injected beats. The driver applies inputs at the falling edge and at once pushes the expected output for the next rising edge into a queue. It computes that value with its own model of the counter, the LFSR and the no-adjacent rule. The monitor pops one item per rising edge, shortly after the edge, and compares all four outputs. Any error in a reload value or in the decrement therefore shows up as a shifted injection cycle.

// File: rtl/unsol_pkg.sv
`timescale 1ns/1ps
package unsol_pkg;

  // Source selected for the registered output beat
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PASS = 2'd1,
    SRC_INJ  = 2'd2
  } beat_src_e;

endpackage

// File: rtl/unsol_lfsr.sv
`timescale 1ns/1ps
module unsol_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv_i,
  output logic [W-1:0] next_o
);

  logic [W-1:0] state_q;
  logic         fb;

  assign fb     = ^(state_q & TAPS);
  assign next_o = {state_q[W-2:0], fb};

  always_ff @(posedge clk) begin
    if (rst)        state_q <= SEED;
    else if (adv_i) state_q <= next_o;
  end

  // R4: a nonzero seed never collapses to the all-zero lock-up state
  p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    adv_i |=> (state_q != '0));

endmodule

// File: rtl/unsol_delay_pick.sv
`timescale 1ns/1ps
module unsol_delay_pick #(
  parameter int CNT_W  = 8,
  parameter int LFSR_W = 16
) (
  input  logic [CNT_W-1:0]  dly_min_i,
  input  logic [CNT_W-1:0]  dly_max_i,
  input  logic [LFSR_W-1:0] rnd_i,
  output logic [CNT_W-1:0]  reload_o
);

  localparam int SPAN_W = CNT_W + 1;
  localparam int MW     = (LFSR_W > SPAN_W) ? LFSR_W : SPAN_W;

  logic [SPAN_W-1:0] span;

  // Reversed bounds collapse to a single legal value: min
  always_comb begin
    if (dly_max_i >= dly_min_i)
      span = SPAN_W'(dly_max_i) - SPAN_W'(dly_min_i) + SPAN_W'(1);
    else
      span = SPAN_W'(1);
  end

  assign reload_o = CNT_W'(MW'(dly_min_i) + (MW'(rnd_i) % MW'(span)));

endmodule

// File: rtl/unsol_pacer.sv
`timescale 1ns/1ps
module unsol_pacer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             idle_i,
  input  logic             req_i,
  input  logic             pass_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             inject_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             last_inj_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign inject_o = en_i & idle_i & ~req_i & ~pass_i & cnt_zero & ~last_inj_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= reload_i;
      last_inj_q <= 1'b0;
    end else if (inject_o) begin
      cnt_q      <= reload_i;
      last_inj_q <= 1'b1;
    end else begin
      last_inj_q <= 1'b0;
      if (en_i && !req_i && !cnt_zero) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R5: an enabled, request-free, non-injecting tick steps a nonzero count down
  p_count_down_r5: assert property (@(posedge clk) disable iff (rst)
    (en_i && !req_i && !inject_o && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R3: a new request freezes the counter
  p_freeze_on_req_r3: assert property (@(posedge clk) disable iff (rst)
    req_i |=> $stable(cnt_q));

  // R7: an injection is never followed directly by another
  p_no_adjacent_r7: assert property (@(posedge clk) disable iff (rst)
    inject_o |=> !inject_o);

endmodule

// File: rtl/unsol_inject.sv
`timescale 1ns/1ps
module unsol_inject #(
  parameter int          DATA_W    = 32,
  parameter int          ECC_W     = 7,
  parameter int          CNT_W     = 8,
  parameter int          OUT_W     = 4,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic [OUT_W-1:0]          outstanding_i,
  input  logic                      req_new_i,
  input  logic [CNT_W-1:0]          dly_min_i,
  input  logic [CNT_W-1:0]          dly_max_i,
  input  logic [DATA_W+ECC_W-1:0]   inj_word_i,
  input  logic                      inj_err_i,
  input  logic                      rsp_valid_i,
  input  logic [DATA_W+ECC_W-1:0]   rsp_word_i,
  input  logic                      rsp_err_i,
  output logic                      rsp_valid_o,
  output logic [DATA_W+ECC_W-1:0]   rsp_word_o,
  output logic                      rsp_err_o,
  output logic                      rsp_unsol_o
);
  import unsol_pkg::*;

  localparam int WORD_W = DATA_W + ECC_W;

  logic [LFSR_W-1:0] lfsr_next;
  logic [LFSR_W-1:0] pick_src;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  cnt;
  logic              inject;
  logic              idle;
  beat_src_e         src;

  assign idle     = (outstanding_i == '0);
  assign pick_src = rst ? LFSR_W'(LFSR_SEED) : lfsr_next;

  unsol_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_W'(LFSR_TAPS)),
    .SEED (LFSR_W'(LFSR_SEED))
  ) u_lfsr (
    .clk    (clk),
    .rst    (rst),
    .adv_i  (inject),
    .next_o (lfsr_next)
  );

  unsol_delay_pick #(
    .CNT_W  (CNT_W),
    .LFSR_W (LFSR_W)
  ) u_pick (
    .dly_min_i (dly_min_i),
    .dly_max_i (dly_max_i),
    .rnd_i     (pick_src),
    .reload_o  (reload)
  );

  unsol_pacer #(
    .CNT_W (CNT_W)
  ) u_pacer (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .idle_i   (idle),
    .req_i    (req_new_i),
    .pass_i   (rsp_valid_i),
    .reload_i (reload),
    .inject_o (inject),
    .cnt_o    (cnt)
  );

  always_comb begin
    if (rsp_valid_i)  src = SRC_PASS;
    else if (inject)  src = SRC_INJ;
    else              src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= 1'b0;
      rsp_unsol_o <= 1'b0;
      rsp_word_o  <= '0;
      rsp_err_o   <= 1'b0;
    end else begin
      case (src)
        SRC_PASS: begin
          rsp_valid_o <= 1'b1;
          rsp_unsol_o <= 1'b0;
          rsp_word_o  <= rsp_word_i;
          rsp_err_o   <= rsp_err_i;
        end
        SRC_INJ: begin
          rsp_valid_o <= 1'b1;
          rsp_unsol_o <= 1'b1;
          rsp_word_o  <= inj_word_i;
          rsp_err_o   <= inj_err_i;
        end
        default: begin
          rsp_valid_o <= 1'b0;
          rsp_unsol_o <= 1'b0;
          rsp_word_o  <= '0;
          rsp_err_o   <= 1'b0;
        end
      endcase
    end
  end

  // R6: the tag never appears without a valid beat
  p_tag_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_unsol_o |-> rsp_valid_o);

  // R2: busy interface blocks injection
  p_idle_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (outstanding_i != '0) |=> !rsp_unsol_o);

  // R3: a new request wins the tick
  p_req_wins_r3: assert property (@(posedge clk) disable iff (rst)
    req_new_i |=> !rsp_unsol_o);

  // R7: valid and tag drop after an injected beat
  p_drop_after_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_unsol_o |=> (!rsp_unsol_o && !rsp_valid_o) || $past(rsp_valid_i));

  // R9: disabled block stays silent
  p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !rsp_unsol_o);

  // R4: reload lands in the configured range
  p_reload_range_r4: assert property (@(posedge clk) disable iff (rst)
    (inject && dly_min_i <= dly_max_i) |=>
      (cnt >= $past(dly_min_i) && cnt <= $past(dly_max_i)));

  // R8: forwarded beat carries the incoming word
  p_pass_word_r8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid_i |=> (rsp_valid_o && !rsp_unsol_o && rsp_word_o == $past(rsp_word_i)));

endmodule

// File: tb/sim_unsol_inject.sv
`timescale 1ns/1ps
module sim_unsol_inject;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ECC_W  = 7;
  localparam int WORD_W = DATA_W + ECC_W;
  localparam int CNT_W  = 8;
  localparam int OUT_W  = 4;
  localparam logic [15:0] SEED = 16'hACE1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en_i = 1'b0;
  logic [OUT_W-1:0]  outstanding_i = '0;
  logic              req_new_i = 1'b0;
  logic [CNT_W-1:0]  dly_min_i = '0;
  logic [CNT_W-1:0]  dly_max_i = 8'd100;
  logic [WORD_W-1:0] inj_word_i = '0;
  logic              inj_err_i = 1'b0;
  logic              rsp_valid_i = 1'b0;
  logic [WORD_W-1:0] rsp_word_i = '0;
  logic              rsp_err_i = 1'b0;
  logic              rsp_valid_o;
  logic [WORD_W-1:0] rsp_word_o;
  logic              rsp_err_o;
  logic              rsp_unsol_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  unsol_inject u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .outstanding_i(outstanding_i),
    .req_new_i(req_new_i), .dly_min_i(dly_min_i), .dly_max_i(dly_max_i),
    .inj_word_i(inj_word_i), .inj_err_i(inj_err_i),
    .rsp_valid_i(rsp_valid_i), .rsp_word_i(rsp_word_i), .rsp_err_i(rsp_err_i),
    .rsp_valid_o(rsp_valid_o), .rsp_word_o(rsp_word_o),
    .rsp_err_o(rsp_err_o), .rsp_unsol_o(rsp_unsol_o)
  );

  typedef struct packed {
    logic              valid;
    logic              tag;
    logic [WORD_W-1:0] word;
    logic              err;
  } beat_t;

  beat_t exp_q[$];
  string id_q[$];
  int    n_checks = 0;
  int    n_fails  = 0;
  int    seen_tags = 0;
  int    model_tags = 0;
  bit    finished = 0;

  // independent reference state
  logic [15:0]      m_lfsr;
  logic [CNT_W-1:0] m_cnt;
  bit               m_last;

  function automatic logic [15:0] lfsr_step(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [CNT_W-1:0] pick(logic [15:0] r);
    int span;
    span = (dly_max_i >= dly_min_i) ? (int'(dly_max_i) - int'(dly_min_i) + 1) : 1;
    return CNT_W'(int'(dly_min_i) + int'(r % 16'(span)));
  endfunction

  task automatic check(string id, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", id, act, exp, $time);
    end
  endtask

  // driver: one tick of stimulus plus the expected beat for the next edge
  task automatic tick(string id, bit r, bit en, int outst, bit req, bit vin);
    beat_t e;
    bit    inj;
    @(negedge clk);
    rst           = r;
    en_i          = en;
    outstanding_i = OUT_W'(outst);
    req_new_i     = req;
    rsp_valid_i   = vin;
    rsp_word_i    = WORD_W'({$urandom(), $urandom()});
    rsp_err_i     = 1'($urandom());
    inj_word_i    = WORD_W'({$urandom(), $urandom()});
    inj_err_i     = 1'($urandom());
    e = '0;
    if (r) begin
      m_lfsr = SEED;
      m_cnt  = pick(SEED);
      m_last = 0;
    end else begin
      inj = en && !req && !vin && (m_cnt == 0) && (outst == 0) && !m_last;
      if (vin) begin
        e.valid = 1; e.word = rsp_word_i; e.err = rsp_err_i;
      end else if (inj) begin
        e.valid = 1; e.tag = 1; e.word = inj_word_i; e.err = inj_err_i;
        model_tags++;
      end
      if (inj) begin
        m_lfsr = lfsr_step(m_lfsr);
        m_cnt  = pick(m_lfsr);
      end else if (en && !req && m_cnt != 0) begin
        m_cnt = m_cnt - 1'b1;
      end
      m_last = inj;
    end
    exp_q.push_back(e);
    id_q.push_back(id);
  endtask

  // monitor: compare each edge's result against the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        beat_t e;
        string id;
        e  = exp_q.pop_front();
        id = id_q.pop_front();
        if (rsp_unsol_o === 1'b1) seen_tags++;
        check({id, " valid"}, 64'(rsp_valid_o), 64'(e.valid));
        check({id, " unsol tag"}, 64'(rsp_unsol_o), 64'(e.tag));
        check({id, " word"}, 64'(rsp_word_o), 64'(e.word));
        check({id, " err"}, 64'(rsp_err_o), 64'(e.err));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog expired, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int t0;
    // R1: reset state with default range 0..100 (R10)
    dly_min_i = 8'd0; dly_max_i = 8'd100;
    for (int i = 0; i < 3; i++) tick("R1", 1, 1, 0, 0, 0);

    // R9 / R8: disabled, normal beats pass, counter frozen
    for (int i = 0; i < 40; i++) tick("R9", 0, 0, 0, 0, (i % 3) == 0);

    // R2: busy interface, no injection while outstanding nonzero
    for (int i = 0; i < 80; i++) tick("R2", 0, 1, 1 + (i % 5), 0, (i % 7) == 0);

    // R4 / R5 / R6 / R3 / R8: idle free run with occasional requests and beats
    t0 = model_tags;
    for (int i = 0; i < 3000; i++)
      tick((i % 37) == 5 ? "R3" : ((i % 53) == 9 ? "R8" : "R4"),
           0, 1, ((i % 211) > 200) ? 2 : 0, (i % 37) == 5, (i % 53) == 9);
    repeat (3) @(negedge clk);
    check("R4 injected beat count", 64'(seen_tags), 64'(model_tags));
    check("R5 injections occurred", 64'(model_tags > t0), 64'(1));

    // R1: mid-run reset reloads from the seed
    for (int i = 0; i < 2; i++) tick("R1", 1, 1, 0, 0, 0);
    for (int i = 0; i < 200; i++) tick("R1", 0, 1, 0, 0, 0);

    // R7: zero range, beats must never be adjacent
    dly_min_i = 8'd0; dly_max_i = 8'd0;
    for (int i = 0; i < 40; i++) tick("R7", 0, 1, 0, 0, 0);

    // R10: reversed range reloads min
    dly_min_i = 8'd7; dly_max_i = 8'd3;
    for (int i = 0; i < 60; i++) tick("R10", 0, 1, 0, 0, 0);

    // R5: fixed delay 100
    dly_min_i = 8'd100; dly_max_i = 8'd100;
    for (int i = 0; i < 320; i++) tick("R5", 0, 1, 0, 0, 0);

    tick("R9", 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule